// File: doc/BRIEF.md
# Three-Wire Security Key Host Controller

This block is the host-side master for a small serial security key that talks over three wires: a framing strobe (here `key_rst`), a serial clock (`key_clk`) and one bidirectional data line. A single `start` pulse launches a whole transaction. The block drives the framing strobe and serial clock from the system clock and shifts out a 24-bit command word. For a normal transfer it then reads the 64-bit identification code and sends the 64-bit compare code. It then reads or writes the 128-bit secure data field. A program transfer writes 128 bits straight after the command. The data pad is split into `dq_o`, `dq_oe` and `dq_i`.

Every delay comes from a counter whose limit is derived from the system clock frequency in MHz. These delays are the strobe-to-first-clock lead time, the clock low and high halves, and the idle gap. When the transfer ends, the collected identification code and read data appear on `id_out` and `rdata` together with a one-cycle `done` pulse.

Top module: `key3w_host`

## Requirements
- R1: After reset, `busy`, `done`, `key_rst`, `key_clk` and `dq_oe` are low, and `id_out` is zero.
- R2: A `start` pulse while idle captures `mode`, `cmd`, `code` and `wdata` and raises `busy`. A `start` while `busy` is ignored: the running transfer keeps its length and bit stream, and `busy` stays high.
- R3: `key_rst` is high at least 1000 ns before the first rising `key_clk` edge. Every low and every high half of `key_clk` lasts at least 125 ns, which keeps the rate at or below 4 MHz.
- R4: `mode` 2'b00 is a normal read and 2'b01 is a normal write. A mode with bit 1 set (2'b10 or 2'b11) is a program transfer. A normal transfer is 280 serial clocks: bit slots 0-23 carry the command, 24-87 the identification read, 88-151 the compare write and 152-279 the data field. A program transfer is 152 clocks: the command, then 128 written bits.
- R5: Every field is sent and received least-significant bit first. In a program transfer `wdata[63:0]` goes first as the identification code, followed by `wdata[127:64]` as the match code.
- R6: A driven data bit changes only at a falling `key_clk` edge. It is therefore settled at least 35 ns before the next rising edge and held at least 40 ns after it.
- R7: `dq_oe` is low during the identification slots and, in read mode, the data slots. `dq_i` is sampled at the end of each low half, which is at least 100 ns after the falling edge.
- R8: At the end of a transfer, `key_rst` falls while `key_clk` is still high, and only after the last rising edge.
- R9: `key_rst` stays low at least 125 ns before `done` and before any new transfer. `done` is high for one cycle. At `done`, `id_out` holds the identification code (zero for program transfers), and `rdata` holds the data read (zero unless read mode).
- R10: `dq_oe` is high only while `key_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transaction (ignored while busy) |
| mode | input | 2 | 00 read, 01 write, 1x program |
| cmd | input | 24 | Command word, sent LSB first |
| code | input | 64 | Compare code for normal transfers |
| wdata | input | 128 | Data to write, or id and match code when programming |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| id_out | output | 64 | Identification code read from the key |
| rdata | output | 128 | Secure data read from the key |
| key_rst | output | 1 | Framing strobe to the key |
| key_clk | output | 1 | Serial clock to the key |
| dq_o | output | 1 | Data pad output value |
| dq_oe | output | 1 | Data pad output enable |
| dq_i | input | 1 | Data pad input value |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a running transfer and asks for a program transfer of different length. The bench raises `start` several hundred cycles into a normal write with a program mode. The key model then confirms that it still saw 280 clocks and the write stream. The bench also has to show that read sampling is late enough. To do this, the key model drives the inverse of each read bit at the falling edge and the true value only 100 ns later, so a host that samples early captures wrong data.

// File: rtl/key3w_host.sv
`timescale 1ns/1ps
module key3w_host #(
  parameter int SYS_MHZ  = 100,
  parameter int HALF_NS  = 125,
  parameter int SETUP_NS = 1000,
  parameter int GAP_NS   = 125
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [23:0]  cmd,
  input  logic [63:0]  code,
  input  logic [127:0] wdata,
  output logic         busy,
  output logic         done,
  output logic [63:0]  id_out,
  output logic [127:0] rdata,
  output logic         key_rst,
  output logic         key_clk,
  output logic         dq_o,
  output logic         dq_oe,
  input  logic         dq_i
);
  localparam int HALF_CYC  = (HALF_NS * SYS_MHZ + 999) / 1000;
  localparam int SETUP_CYC = (SETUP_NS * SYS_MHZ + 999) / 1000;
  localparam int GAP_CYC   = (GAP_NS * SYS_MHZ + 999) / 1000;
  localparam int MAX_A     = SETUP_CYC > HALF_CYC ? SETUP_CYC : HALF_CYC;
  localparam int MAX_CYC   = MAX_A > GAP_CYC ? MAX_A : GAP_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam logic [8:0] CMD_END  = 9'd24;
  localparam logic [8:0] ID_END   = 9'd88;
  localparam logic [8:0] CODE_END = 9'd152;
  localparam logic [8:0] NORM_LAST = 9'd279;
  localparam logic [8:0] PROG_LAST = 9'd151;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_DROP, S_GAP} st_t;
  st_t st;
  logic [1:0]   mode_q;
  logic [23:0]  cmd_q;
  logic [63:0]  code_q;
  logic [127:0] wdata_q;
  logic [8:0]   idx;
  logic [CW-1:0] cnt;

  wire prog     = mode_q[1];
  wire rd_mode  = (mode_q == 2'b00);
  wire [8:0] last = prog ? PROG_LAST : NORM_LAST;
  wire id_slot  = !prog && idx >= CMD_END && idx < ID_END;
  wire dat_slot = rd_mode && idx >= CODE_END;
  wire [8:0] off_p = idx - CMD_END;
  wire [8:0] off_c = idx - ID_END;
  wire [8:0] off_d = idx - CODE_END;

  assign busy    = (st != S_IDLE);
  assign key_rst = (st == S_SETUP) || (st == S_LOW) || (st == S_HIGH);
  assign key_clk = (st == S_HIGH) || (st == S_DROP);
  assign dq_oe   = ((st == S_LOW) || (st == S_HIGH)) && !(id_slot || dat_slot);

  always_comb begin
    if (idx < CMD_END)       dq_o = cmd_q[idx[4:0]];
    else if (prog)           dq_o = wdata_q[off_p[6:0]];
    else if (idx < CODE_END) dq_o = code_q[off_c[5:0]];
    else                     dq_o = wdata_q[off_d[6:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; done <= 1'b0;
      mode_q <= '0; cmd_q <= '0; code_q <= '0; wdata_q <= '0;
      id_out <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode; cmd_q <= cmd; code_q <= code; wdata_q <= wdata;
          id_out <= '0; rdata <= '0; idx <= '0;
          cnt <= CW'(SETUP_CYC - 1); st <= S_SETUP;
        end
        S_SETUP: if (cnt == '0) begin
          cnt <= CW'(HALF_CYC - 1); st <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt == '0) begin
          if (id_slot)  id_out <= {dq_i, id_out[63:1]};
          if (dat_slot) rdata  <= {dq_i, rdata[127:1]};
          cnt <= CW'(HALF_CYC - 1); st <= S_HIGH;
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt == '0) begin
          if (idx == last) st <= S_DROP;
          else begin
            idx <= idx + 1'b1; cnt <= CW'(HALF_CYC - 1); st <= S_LOW;
          end
        end else cnt <= cnt - 1'b1;
        S_DROP: begin cnt <= CW'(GAP_CYC - 1); st <= S_GAP; end
        S_GAP: if (cnt == '0) begin
          st <= S_IDLE; done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [15:0] hi_n, lo_n, rh_n, rl_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_n <= '0; lo_n <= '0; rh_n <= '0; rl_n <= 16'hFFFF;
    end else begin
      hi_n <= !key_clk ? '0 : (hi_n == 16'hFFFF ? hi_n : hi_n + 1'b1);
      lo_n <=  key_clk ? '0 : (lo_n == 16'hFFFF ? lo_n : lo_n + 1'b1);
      rh_n <= !key_rst ? '0 : (rh_n == 16'hFFFF ? rh_n : rh_n + 1'b1);
      rl_n <=  key_rst ? '0 : (rl_n == 16'hFFFF ? rl_n : rl_n + 1'b1);
    end
  end

  // R3
  clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_clk) |-> hi_n >= 16'(HALF_CYC));
  // R3
  clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_clk) |-> lo_n >= 16'(HALF_CYC));
  // R3
  rst_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_clk) |-> rh_n >= 16'(SETUP_CYC));
  // R9
  rst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_rst) |-> rl_n >= 16'(GAP_CYC));
  // R8
  rst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_rst) |-> key_clk);
  // R10
  oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> key_rst);
  // R6
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_clk && $past(key_clk) && dq_oe |-> $stable(dq_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && key_rst |=> busy);
endmodule

// File: tb/sim_key3w_host.sv
`timescale 1ns/1ps
module sim_key3w_host;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dq_i = 1'b0;
  logic [1:0] mode = '0;
  logic [23:0] cmd = '0;
  logic [63:0] code = '0;
  logic [127:0] wdata = '0;
  logic busy, done, key_rst, key_clk, dq_o, dq_oe;
  logic [63:0] id_out;
  logic [127:0] rdata;

  always #5 clk = ~clk;

  key3w_host u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cmd(cmd),
    .code(code), .wdata(wdata), .busy(busy), .done(done), .id_out(id_out),
    .rdata(rdata), .key_rst(key_rst), .key_clk(key_clk), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [279:0] act, input logic [279:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // key model
  logic [63:0] key_id = '0;
  logic [127:0] key_mem = '0;
  logic [1:0] cur_mode = '0;
  logic [279:0] cap = '0, capoe = '0;
  int k = 0, viol = 0;
  time t_rise = 0, t_fall = 0, t_rrise = 0, t_rfall = 0, t_dq = 0;

  initial begin : model
    logic pr, pc, first, v;
    pr = 1'b0; pc = 1'b0; first = 1'b0;
    forever begin
      @(key_rst or key_clk);
      if (key_rst && !pr) begin
        if ($time - t_rfall < 125) viol++;
        t_rrise = $time; k = 0; cap = '0; capoe = '0; first = 1'b1;
      end
      if (!key_rst && pr) begin
        if (!key_clk) viol++;
        t_rfall = $time;
      end
      if (key_clk && !pc && key_rst) begin
        if (first) begin
          if ($time - t_rrise < 1000) viol++;
          first = 1'b0;
        end else if ($time - t_fall < 125) viol++;
        if (dq_oe && $time - t_dq < 35) viol++;
        if (k < 280) begin cap[k] = dq_o & dq_oe; capoe[k] = dq_oe; end
        k++; t_rise = $time;
      end
      if (!key_clk && pc && key_rst) begin
        if ($time - t_rise < 125) viol++;
        t_fall = $time;
        v = 1'b0;
        if (!cur_mode[1] && k >= 24 && k < 88) v = key_id[k-24];
        if (cur_mode == 2'b00 && k >= 152 && k < 280) v = key_mem[k-152];
        dq_i = ~v;
        fork begin
          automatic logic vv = v;
          #100; dq_i = vv;
        end join_none
      end
      pr = key_rst; pc = key_clk;
    end
  end

  always @(dq_o or dq_oe) begin
    if (key_rst && $time - t_rise < 40) viol++;
    t_dq = $time;
  end

  // scoreboard
  logic [63:0] q_id[$];
  logic [127:0] q_rd[$];
  logic [279:0] q_w[$], q_m[$];
  int q_n[$];

  task automatic run(input logic [1:0] m, input logic [23:0] c, input logic [63:0] cd,
                     input logic [127:0] wd, input logic [63:0] kid, input logic [127:0] kmem);
    logic [279:0] w, msk;
    int n;
    w = '0; msk = '0;
    w[23:0] = c; msk[23:0] = '1;
    if (m[1]) begin
      w[151:24] = wd; msk[151:24] = '1; n = 152;
    end else begin
      w[151:88] = cd; msk[151:88] = '1; n = 280;
      if (m[0]) begin w[279:152] = wd; msk[279:152] = '1; end
    end
    q_w.push_back(w); q_m.push_back(msk); q_n.push_back(n);
    q_id.push_back(m[1] ? 64'h0 : kid);
    q_rd.push_back(m == 2'b00 ? kmem : 128'h0);
    @(negedge clk);
    while (busy) @(negedge clk);
    key_id = kid; key_mem = kmem; cur_mode = m;
    mode = m; cmd = c; code = cd; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = ~m; cmd = ~c; code = ~cd; wdata = ~wd;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done && q_n.size() != 0) begin
        logic [279:0] ew, em;
        ew = q_w.pop_front(); em = q_m.pop_front();
        chk(id_out == q_id[0], "R5 id_out LSB-first", 280'(id_out), 280'(q_id[0]));
        chk(rdata == q_rd[0], "R7 rdata sampled", 280'(rdata), 280'(q_rd[0]));
        chk((cap & em) == ew, "R4 written stream", cap & em, ew);
        chk(capoe == em, "R7 dq_oe per slot", capoe, em);
        chk(k == q_n[0], "R4 clock count", 280'(k), 280'(q_n[0]));
        chk(viol == 0, "R3 R6 R8 R9 timing", 280'(viol), 280'(0));
        chk(!key_rst && !dq_oe, "R10 idle pad at done", {key_rst, dq_oe}, 280'(0));
        void'(q_id.pop_front()); void'(q_rd.pop_front()); void'(q_n.pop_front());
        viol = 0;
        @(negedge clk);
        chk(!done, "R9 done single cycle", 280'(done), 280'(0));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    #23;
    chk(!busy && !done, "R1 busy/done reset", {busy, done}, 280'(0));
    chk(!key_rst && !key_clk, "R1 key_rst/key_clk reset", {key_rst, key_clk}, 280'(0));
    chk(!dq_oe, "R1 dq_oe reset", 280'(dq_oe), 280'(0));
    chk(id_out == 64'h0, "R1 id_out reset", 280'(id_out), 280'(0));
    #20 rst_n = 1'b1;
    repeat (30) @(negedge clk);
    run(2'b00, 24'hA5C3E1, 64'h0123_4567_89AB_CDEF, 128'h0,
        64'hDEAD_BEEF_1357_9BDF, 128'hF00D_CAFE_0000_FFFF_8001_7FFE_AAAA_5555);
    run(2'b01, 24'h3C96F0, 64'hFEDC_BA98_7654_3210, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
        64'h8000_0000_0000_0001, 128'h0);
    repeat (400) @(negedge clk);
    mode = 2'b10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 start while busy ignored", 280'(busy), 280'(1));
    run(2'b10, 24'h800001, 64'h0, 128'hC001_D00D_0F0F_F0F0_1234_5678_9ABC_DEF0,
        64'h5555_AAAA_5555_AAAA, 128'h0);
    run(2'b11, 24'h7FFFFE, 64'h0, 128'h8000_0000_0000_0000_0000_0000_0000_0001,
        64'h1, 128'h0);
    run(2'b00, 24'hFFFFFF, 64'h0, 128'h0,
        64'h0F1E_2D3C_4B5A_6978, 128'h8000_0000_0000_0000_0000_0000_0000_0001);
    run(2'b00, 24'h000000, 64'hFFFF_FFFF_FFFF_FFFF, 128'h0,
        64'hFFFF_FFFF_0000_0000, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    while (q_n.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule